// File: doc/BRIEF.md
# Windowed Correlation Peak Locator

This block sits after a correlator in a packet receiver and turns a stream of correlation magnitudes into one timing index. A one-cycle `start` pulse opens a search window of a fixed number of accepted samples. The block then counts every accepted sample and runs one of two searches on it. The `mode` input picks the search, and `mode` and `threshold` are both captured on the `start` cycle. In largest-value mode the block reports where the biggest magnitude occurred. In first-crossing mode it reports the first sample whose magnitude is strictly above the captured threshold. If no sample in the window crosses, it raises a miss flag.

Magnitudes arrive on a valid/ready stream. The block never applies back-pressure: `s_ready` is held high, so a sample is accepted in every cycle where `s_valid` is high. Idle cycles with `s_valid` low do not advance the index. The result is a registered index with a one-cycle `done` pulse, and it stays on the outputs until a later search completes. With no timing error, the expected index for the default 100-sample window is about 88.

Top module: `peak_locator`

## Requirements
- R1: After reset, `done` is 0, `res_index` is 0, `res_miss` is 0 and `s_ready` is 1.
- R2: `s_ready` stays high. Only cycles with `s_valid` high count as samples, and the first accepted sample after `start` has index 0.
- R3: Only the first WINDOW (default 100) accepted samples after `start` take part in a search. Samples accepted after that have no effect, and a reported index is always below WINDOW.
- R4: With `mode`=0 (largest value), the block reports the index of the largest magnitude in the window. When values tie, the earliest index is kept.
- R5: With `mode`=0, `done` is a single-cycle pulse. It appears in the cycle after the one that accepts the last window sample, and `res_miss` is 0.
- R6: With `mode`=1 (first crossing), the block reports the index of the first sample with magnitude strictly greater than the threshold, so a magnitude equal to the threshold does not count. `done` pulses in the cycle after that sample is accepted, and later samples have no effect.
- R7: With `mode`=1 and no crossing in the window, `done` pulses in the cycle after the last window sample, with `res_miss`=1 and `res_index`=0.
- R8: `mode` and `threshold` are captured on the `start` cycle. Changing them during a search has no effect on that search.
- R9: `res_index` and `res_miss` only change together with a `done` pulse. A `start` during a search discards that search and restarts the index at 0.
- R10: A sample presented in the same cycle as `start` is not part of the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a new search window |
| mode | input | 1 | 0 = largest value, 1 = first crossing |
| threshold | input | W | Crossing level, captured on start |
| s_valid | input | 1 | Magnitude sample valid |
| s_ready | output | 1 | Always high |
| s_mag | input | W | Unsigned correlation magnitude |
| done | output | 1 | One-cycle result pulse |
| res_index | output | $clog2(WINDOW) | Timing index of the last result |
| res_miss | output | 1 | No crossing found (first-crossing mode) |

## Verification
Largest-value mode is exercised with three input patterns:
- a ramp topped by an isolated peak, which checks plain peak finding;
- two equal maxima followed by a larger value just past the window, which separates earliest-tie handling from later-tie handling and checks the window limit;
- a peak in a stream with idle gaps, which shows whether gap cycles wrongly advance the index.

First-crossing mode is driven with a ramp that lands exactly on the threshold one sample before it exceeds it, which separates a strict comparison from an inclusive one. A second first-crossing run never crosses, which exercises the miss path.

On every search, the stimulus also does the following:
- drives a saturated sample during the `start` cycle;
- inverts `mode` and zeroes `threshold` once the search has started;
- sends saturated values during idle cycles.

Finally, a search that is cut short and then restarted checks that the earlier result is held and that the restart discards the samples taken before it.

// File: rtl/pl_pkg.sv
package pl_pkg;
  typedef enum logic {
    PL_LARGEST = 1'b0,
    PL_FIRST   = 1'b1
  } pl_mode_e;
endpackage

// File: rtl/pl_window_ctr.sv
// Counts accepted samples inside the search window.
module pl_window_ctr #(
  parameter int WINDOW = 100,
  localparam int IW = $clog2(WINDOW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  input  logic          in_valid,
  output logic          adv,
  output logic          last,
  output logic [IW-1:0] idx
);
  logic active;

  // a start cycle never counts as a window sample
  assign adv  = active & in_valid & ~start;
  assign last = adv & (idx == IW'(WINDOW - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (start) begin
      active <= 1'b1;
      idx    <= '0;
    end else if (adv) begin
      if (last || stop) active <= 1'b0;
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/pl_max_track.sv
// Tracks the earliest index of the largest magnitude seen so far.
module pl_max_track #(
  parameter int W = 16,
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          adv,
  input  logic [W-1:0]  mag,
  input  logic [IW-1:0] idx,
  output logic [IW-1:0] best_nxt
);
  logic [W-1:0]  best_val;
  logic [IW-1:0] best_idx;
  logic          have;
  logic          upd;

  // strict greater-than keeps the earliest of equal values
  assign upd      = adv & (~have | (mag > best_val));
  assign best_nxt = upd ? idx : best_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      best_val <= '0;
      best_idx <= '0;
      have     <= 1'b0;
    end else if (start) begin
      best_val <= '0;
      best_idx <= '0;
      have     <= 1'b0;
    end else if (upd) begin
      best_val <= mag;
      best_idx <= idx;
      have     <= 1'b1;
    end
  end
endmodule

// File: rtl/pl_cross_det.sv
// Captures the threshold on start and flags a strict crossing.
module pl_cross_det #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] thr_in,
  input  logic         adv,
  input  logic [W-1:0] mag,
  output logic         hit,
  output logic [W-1:0] thr_q
);
  assign hit = adv & (mag > thr_q);

  always_ff @(posedge clk) begin
    if (!rst_n)     thr_q <= '0;
    else if (start) thr_q <= thr_in;
  end
endmodule

// File: rtl/peak_locator.sv
module peak_locator
  import pl_pkg::*;
#(
  parameter int W = 16,
  parameter int WINDOW = 100,
  localparam int IW = $clog2(WINDOW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode,
  input  logic [W-1:0]  threshold,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [W-1:0]  s_mag,
  output logic          done,
  output logic [IW-1:0] res_index,
  output logic          res_miss
);
  pl_mode_e      mode_q;
  logic          adv, last, hit, hit_eff, fin;
  logic [IW-1:0] idx, best_nxt;
  logic [W-1:0]  thr_q;

  assign s_ready = 1'b1;
  assign hit_eff = (mode_q == PL_FIRST) & hit;
  assign fin     = last | hit_eff;

  pl_window_ctr #(.WINDOW(WINDOW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(hit_eff),
    .in_valid(s_valid), .adv(adv), .last(last), .idx(idx)
  );

  pl_max_track #(.W(W), .IW(IW)) u_max (
    .clk(clk), .rst_n(rst_n), .start(start), .adv(adv),
    .mag(s_mag), .idx(idx), .best_nxt(best_nxt)
  );

  pl_cross_det #(.W(W)) u_cross (
    .clk(clk), .rst_n(rst_n), .start(start), .thr_in(threshold),
    .adv(adv), .mag(s_mag), .hit(hit), .thr_q(thr_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= PL_LARGEST;
      done      <= 1'b0;
      res_index <= '0;
      res_miss  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        mode_q <= pl_mode_e'(mode);
      end else if (fin) begin
        done <= 1'b1;
        if (mode_q == PL_LARGEST) begin
          res_index <= best_nxt;
          res_miss  <= 1'b0;
        end else if (hit_eff) begin
          res_index <= idx;
          res_miss  <= 1'b0;
        end else begin
          res_index <= '0;
          res_miss  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pl_peak_locator_chk.sv
module pl_peak_locator_chk #(
  parameter int W = 16,
  parameter int WINDOW = 100,
  localparam int IW = $clog2(WINDOW)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic [IW-1:0] res_index,
  input logic          res_miss,
  input logic          mode_q,
  input logic [W-1:0]  s_mag,
  input logic [W-1:0]  thr_q
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R5
  AST_INDEX_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ({1'b0, res_index} < (IW+1)'(WINDOW))); // R3
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(res_index) && $stable(res_miss))); // R9
  AST_LARGEST_NO_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode_q) |-> !res_miss); // R5
  AST_MISS_ZERO_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_miss) |-> (res_index == '0)); // R7
  AST_CROSS_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q && !res_miss) |-> ($past(s_mag) > $past(thr_q))); // R6
endmodule

bind peak_locator pl_peak_locator_chk #(.W(W), .WINDOW(WINDOW)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .res_index(res_index),
  .res_miss(res_miss), .mode_q(mode_q), .s_mag(s_mag), .thr_q(thr_q)
);

// File: tb/peak_locator_bench.sv
module peak_locator_bench;
  localparam int W = 16;
  localparam int WIN = 100;
  localparam int IW = $clog2(WIN);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, mode = 1'b0, s_valid = 1'b0;
  logic [W-1:0] threshold = '0, s_mag = '0;
  logic s_ready, done, res_miss;
  logic [IW-1:0] res_index;

  int checks = 0, failures = 0;
  int    exp_idx_q[$];
  bit    exp_miss_q[$];
  string exp_tag_q[$];
  logic [W-1:0] vals [0:127];
  int last_idx = 0;
  bit last_miss = 0;

  always #5 clk = ~clk;

  peak_locator #(.W(W), .WINDOW(WIN)) u_peak_locator (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .threshold(threshold),
    .s_valid(s_valid), .s_ready(s_ready), .s_mag(s_mag), .done(done),
    .res_index(res_index), .res_miss(res_miss)
  );

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  // monitor: compares each result against the scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_idx_q.size() == 0) begin
        check(1'b0, "R9 unexpected done", 1, 0);
      end else begin
        int ei; bit em; string et;
        ei = exp_idx_q.pop_front();
        em = exp_miss_q.pop_front();
        et = exp_tag_q.pop_front();
        check(int'(res_index) == ei, {et, " index"}, int'(res_index), ei);
        check(res_miss == em, {et, " miss"}, int'(res_miss), int'(em));
      end
    end
  end

  // driver: builds the expectation, then drives the search
  task automatic search(input logic md, input int thr, input int n,
                        input int gap, input string tag);
    int dpos, bidx, bval, lim;
    bit miss;
    lim = (n < WIN) ? n : WIN;
    dpos = -1; bidx = 0; miss = 0;
    if (md == 1'b0) begin
      bval = -1;
      for (int k = 0; k < lim; k++)
        if (int'(vals[k]) > bval) begin bval = int'(vals[k]); bidx = k; end
      if (n >= WIN) dpos = WIN - 1;
    end else begin
      for (int k = 0; k < lim; k++)
        if (dpos < 0 && int'(vals[k]) > thr) begin dpos = k; bidx = k; end
      if (dpos < 0 && n >= WIN) begin dpos = WIN - 1; miss = 1; bidx = 0; end
    end
    if (dpos >= 0) begin
      exp_idx_q.push_back(bidx);
      exp_miss_q.push_back(miss);
      exp_tag_q.push_back(tag);
      last_idx = bidx;
      last_miss = miss;
    end
    @(negedge clk);
    start = 1'b1; mode = md; threshold = W'(thr);
    s_valid = 1'b1; s_mag = '1;          // R10: start-cycle sample is outside the window
    @(negedge clk);
    start = 1'b0; mode = ~md; threshold = '0;   // R8: late changes are ignored
    for (int k = 0; k < n; k++) begin
      if (gap > 0 && (k % gap) == 0) begin
        s_valid = 1'b0; s_mag = '1;      // R2: idle cycles carry saturated data
        @(negedge clk);
        check(done == 1'b0, {tag, " R2 idle done"}, int'(done), 0);
      end
      s_valid = 1'b1; s_mag = vals[k];
      @(negedge clk);
      check(done == (k == dpos), {tag, " done timing"}, int'(done), int'(k == dpos));
    end
    s_valid = 1'b0; s_mag = '0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && res_index == '0 && res_miss == 1'b0, "R1 reset outputs",
          int'(res_index), 0);
    check(s_ready == 1'b1, "R1 R2 ready", int'(s_ready), 1);

    // R4 R5: ramp with a peak at the nominal point
    for (int k = 0; k < 128; k++) vals[k] = W'(k * 3);
    vals[88] = W'(1000);
    search(1'b0, 0, 100, 0, "R4 R5 peak");

    // R4 R3: equal maxima, larger value after the window
    for (int k = 0; k < 128; k++) vals[k] = W'(k % 17);
    vals[20] = W'(700); vals[70] = W'(700); vals[110] = W'(9000);
    search(1'b0, 0, 120, 0, "R4 R3 tie");

    // R6 R8: ramp touches the threshold, then exceeds it
    for (int k = 0; k < 128; k++) vals[k] = W'(k * 10);
    search(1'b1, 500, 110, 0, "R6 R8 cross");

    // R7: no crossing, with idle gaps
    for (int k = 0; k < 128; k++) vals[k] = W'(k);
    search(1'b1, 5000, 100, 7, "R7 R2 miss");

    // R2: peak among idle gaps
    for (int k = 0; k < 128; k++) vals[k] = W'(50 + (k % 5));
    vals[40] = W'(800);
    search(1'b0, 0, 100, 3, "R2 R4 gaps");

    // R9: partial search, result held, restart discards earlier samples
    for (int k = 0; k < 128; k++) vals[k] = W'(k % 9);
    vals[10] = W'(60000);
    search(1'b0, 0, 30, 0, "R9 partial");
    check(int'(res_index) == last_idx && res_miss == last_miss, "R9 held result",
          int'(res_index), last_idx);
    vals[10] = W'(3);
    vals[60] = W'(200);
    search(1'b0, 0, 100, 0, "R9 restart");

    check(exp_idx_q.size() == 0, "R5 R6 all results seen", exp_idx_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    checks++; failures++;
    $display("FAIL watchdog expired R9 got=1 exp=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule